// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is an SPI master that runs one burst of up to 16M-1 bytes in SPI mode 0. It has a 64-byte transmit FIFO and a 64-byte receive FIFO. A host presents a burst length, a transmit count, a clock divider and a pause-enable bit, then pulses start. Only the first bytes of the burst, up to the transmit count, come from the transmit FIFO. Every later byte of the burst is sent as 0x00. Every byte received on MISO is pushed into the receive FIFO, and the host pops it from there.

Bursts longer than a FIFO are kept lossless by flow control at byte boundaries. The serial clock is held low when transmit data is owed but the transmit FIFO is empty. When pause mode is enabled, it is also held low when the receive FIFO is full. The host sees both FIFO fill levels, a busy flag and a one-cycle completion pulse.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, csN is 1, sclk is 0, busy and doneEvt are 0, and both FIFO levels are 0.
- R2: Bytes taken from the transmit FIFO leave on MOSI most significant bit first, in push order. MOSI is stable at each rising sclk edge (mode 0: clock idles low).
- R3: Each byte received on MISO, sampled on rising sclk edges with the MSB first, is placed in the receive FIFO in order and is readable at rxData with rxPop.
- R4: After txLen bytes of the burst have been sent, every remaining byte of the burst is sent as 0x00 and does not touch the transmit FIFO.
- R5: When a byte from the transmit FIFO is due and that FIFO is empty, sclk stays low with csN asserted until data arrives. The burst then resumes with no byte lost.
- R6: With pause enabled, no new byte starts while the receive FIFO holds 64 bytes. Shifting resumes after the host pops, and no received byte is lost.
- R7: With pause disabled, the burst runs to completion even though the receive FIFO is full. The first 64 received bytes are kept and later bytes are dropped.
- R8: doneEvt pulses high for exactly one cycle, in the first cycle in which csN is high again after the last byte. busy is low in that cycle.
- R9: Each sclk high phase lasts clkDiv+1 system clock cycles.
- R10: A start pulse while busy is ignored: the running burst keeps its length. A start with burstLen equal to 0 is ignored: busy stays 0.
- R11: txLevel and rxLevel report the FIFO occupancy from 0 to 64. A push into a full transmit FIFO and a pop from an empty receive FIFO are ignored.
- R12: csN falls at least one half period (clkDiv+1 cycles) before the first rising sclk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a burst |
| burstLen | input | 24 | Total bytes in the burst, captured at start |
| txLen | input | 24 | Bytes taken from the transmit FIFO, captured at start |
| pauseEn | input | 1 | Freeze shifting while the receive FIFO is full |
| clkDiv | input | 8 | Half period of sclk minus one, in system cycles |
| txPush | input | 1 | Push txData into the transmit FIFO |
| txData | input | 8 | Transmit byte |
| rxPop | input | 1 | Pop the head of the receive FIFO |
| rxData | output | 8 | Head of the receive FIFO |
| txLevel | output | 7 | Transmit FIFO occupancy |
| rxLevel | output | 7 | Receive FIFO occupancy |
| busy | output | 1 | A burst is in progress |
| doneEvt | output | 1 | One-cycle burst-complete pulse |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |

## Verification
A corrupted bit counter or shift register shows up within one byte time as a wrong byte at the slave model or in the receive FIFO. A corrupted byte counter shows up at the end of the burst, as too many or too few bytes seen by the slave and a misplaced doneEvt. Wrong stall logic shows up within a few hundred cycles, in one of two ways: sclk edges appear while the bench withholds transmit data or receive space, or received bytes are missing when the bench later drains the FIFO.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOAD, ST_LOW, ST_HIGH, ST_TRAIL
  } sbeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadByte;   // load the shifter at a byte boundary
    logic useFifo;    // load source: TX FIFO head (1) or zero fill (0)
    logic sampleBit;  // capture miso on the rising sclk edge
    logic shiftBit;   // advance mosi on the falling sclk edge
    logic pushRx;     // store the completed byte
  } sbeStrobe_t;
endpackage

// File: rtl/sbe_fifo.sv
module sbe_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           popData,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] count;
  logic doPush, doPop;

  assign doPush = push && (count != LW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign popData = mem[rdPtr];
  assign level = count;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + LW'(1);
        2'b01:   count <= count - LW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    count <= LW'(DEPTH));
  assert_full_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (count == LW'(DEPTH) && push && !pop) |=> count == LW'(DEPTH));
endmodule

// File: rtl/sbe_datapath.sv
module sbe_datapath import sbe_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  sbeStrobe_t       strobe,
  input  logic             txPush,
  input  logic [7:0]       txData,
  input  logic             rxPop,
  output logic [7:0]       rxData,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic             txEmpty,
  output logic             rxFull,
  input  logic             miso,
  output logic             mosi
);
  logic [7:0] txHead, txShift, rxShift;
  logic txPop;

  assign txPop   = strobe.loadByte && strobe.useFifo;
  assign txEmpty = (txLevel == '0);
  assign rxFull  = (rxLevel == LVL_W'(DEPTH));
  assign mosi    = txShift[7];

  sbe_fifo #(.WIDTH(8), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(txData),
    .pop(txPop), .popData(txHead), .level(txLevel));

  sbe_fifo #(.WIDTH(8), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(strobe.pushRx), .pushData(rxShift),
    .pop(rxPop), .popData(rxData), .level(rxLevel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.loadByte)      txShift <= strobe.useFifo ? txHead : 8'h00;
      else if (strobe.shiftBit) txShift <= {txShift[6:0], 1'b0};
      if (strobe.sampleBit)     rxShift <= {rxShift[6:0], miso};
    end
  end

  // a FIFO-sourced load never happens on an empty TX FIFO
  assert_tx_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadByte && strobe.useFifo) |-> !txEmpty);
  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadByte && !strobe.useFifo) |=> (mosi == 1'b0));
endmodule

// File: rtl/sbe_ctrl.sv
module sbe_ctrl import sbe_pkg::*; #(
  parameter int LEN_W = 24,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] burstLen,
  input  logic [LEN_W-1:0] txLen,
  input  logic             pauseEn,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             txEmpty,
  input  logic             rxFull,
  output sbeStrobe_t       strobe,
  output logic             sclk,
  output logic             csN,
  output logic             busy,
  output logic             doneEvt
);
  sbeState_t state, nextState;
  logic [DIV_W-1:0] divCnt, divReg;
  logic [2:0] bitCnt;
  logic [LEN_W-1:0] byteCnt, burstReg, txReg;
  logic pauseReg;
  logic halfDone, txOwed, lastByte, stallLoad, accept;

  assign halfDone  = (divCnt == divReg);
  assign txOwed    = (byteCnt < txReg);
  assign lastByte  = ((byteCnt + LEN_W'(1)) == burstReg);
  assign stallLoad = (txOwed && txEmpty) || (pauseReg && rxFull);
  assign accept    = start && (burstLen != '0);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    strobe = '0;
    case (state)
      ST_IDLE:  if (accept) nextState = ST_LEAD;
      ST_LEAD:  if (halfDone) nextState = ST_LOAD;
      ST_LOAD:  if (!stallLoad) begin
                  strobe.loadByte = 1'b1;
                  strobe.useFifo  = txOwed;
                  nextState = ST_LOW;
                end
      ST_LOW:   if (halfDone) begin
                  strobe.sampleBit = 1'b1;
                  nextState = ST_HIGH;
                end
      ST_HIGH:  if (halfDone) begin
                  if (bitCnt == 3'd7) begin
                    strobe.pushRx = 1'b1;
                    nextState = lastByte ? ST_TRAIL : ST_LOAD;
                  end else begin
                    strobe.shiftBit = 1'b1;
                    nextState = ST_LOW;
                  end
                end
      ST_TRAIL: if (halfDone) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sclk     <= 1'b0;
      csN      <= 1'b1;
      doneEvt  <= 1'b0;
      divCnt   <= '0;
      divReg   <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      burstReg <= '0;
      txReg    <= '0;
      pauseReg <= 1'b0;
    end else begin
      state   <= nextState;
      sclk    <= (nextState == ST_HIGH);
      csN     <= (nextState == ST_IDLE);
      doneEvt <= (state == ST_TRAIL) && (nextState == ST_IDLE);
      if (nextState != state || state == ST_LOAD) divCnt <= '0;
      else divCnt <= divCnt + DIV_W'(1);
      if (state == ST_IDLE && accept) begin
        burstReg <= burstLen;
        txReg    <= txLen;
        divReg   <= clkDiv;
        pauseReg <= pauseEn;
        byteCnt  <= '0;
      end
      if (strobe.loadByte)      bitCnt <= '0;
      else if (strobe.shiftBit) bitCnt <= bitCnt + 3'd1;
      if (strobe.pushRx) byteCnt <= byteCnt + LEN_W'(1);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |=> !doneEvt);
  assert_done_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> (csN && !busy));
  assert_pause_room_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReg && strobe.pushRx) |-> !rxFull);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(burstReg));
  assert_stall_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && stallLoad) |=> !sclk);
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine import sbe_pkg::*; #(
  parameter int FIFO_DEPTH = 64,
  parameter int LEN_W      = 24,
  parameter int DIV_W      = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [LEN_W-1:0]              burstLen,
  input  logic [LEN_W-1:0]              txLen,
  input  logic                          pauseEn,
  input  logic [DIV_W-1:0]              clkDiv,
  input  logic                          txPush,
  input  logic [7:0]                    txData,
  input  logic                          rxPop,
  output logic [7:0]                    rxData,
  output logic [$clog2(FIFO_DEPTH):0]   txLevel,
  output logic [$clog2(FIFO_DEPTH):0]   rxLevel,
  output logic                          busy,
  output logic                          doneEvt,
  output logic                          sclk,
  output logic                          mosi,
  input  logic                          miso,
  output logic                          csN
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  sbeStrobe_t strobe;
  logic txEmpty, rxFull;

  sbe_ctrl #(.LEN_W(LEN_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .burstLen(burstLen),
    .txLen(txLen), .pauseEn(pauseEn), .clkDiv(clkDiv),
    .txEmpty(txEmpty), .rxFull(rxFull), .strobe(strobe),
    .sclk(sclk), .csN(csN), .busy(busy), .doneEvt(doneEvt));

  sbe_datapath #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txPush(txPush),
    .txData(txData), .rxPop(rxPop), .rxData(rxData),
    .txLevel(txLevel), .rxLevel(rxLevel), .txEmpty(txEmpty),
    .rxFull(rxFull), .miso(miso), .mosi(mosi));
endmodule

// File: tb/sim_spi_burst_engine.sv
module sim_spi_burst_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [23:0] burstLen = '0;
  logic [23:0] txLen = '0;
  logic pauseEn = 1'b0;
  logic [7:0] clkDiv = '0;
  logic txPush = 1'b0;
  logic [7:0] txData = '0;
  logic rxPop = 1'b0;
  logic [7:0] rxData;
  logic [6:0] txLevel, rxLevel;
  logic busy, doneEvt, sclk, mosi, csN;
  logic miso = 1'b0;

  int vecs = 0;
  int errs = 0;
  int doneCount = 0;
  int sclkRises = 0;
  bit finished = 1'b0;
  string monTag = "R2";
  logic [7:0] expMosi[$];

  always #10 clk = ~clk;

  spi_burst_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .burstLen(burstLen),
    .txLen(txLen), .pauseEn(pauseEn), .clkDiv(clkDiv), .txPush(txPush),
    .txData(txData), .rxPop(rxPop), .rxData(rxData), .txLevel(txLevel),
    .rxLevel(rxLevel), .busy(busy), .doneEvt(doneEvt), .sclk(sclk),
    .mosi(mosi), .miso(miso), .csN(csN));

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 37 + 90);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model, mode 0: sample on rise, change on fall
  int slvIdx = 0;
  int slvBits = 0;
  logic [7:0] slvByte = '0;
  logic [7:0] slvIn = '0;
  bit lastSclk = 1'b0;
  always @(negedge csN or posedge sclk or negedge sclk) begin
    if (sclk) begin
      lastSclk = 1'b1;
      sclkRises++;
      slvIn = {slvIn[6:0], mosi};
      slvBits++;
      if (slvBits == 8) begin
        // monitor: compare against the scoreboard queue
        if (expMosi.size() == 0) chk(1'b0, monTag, int'(slvIn), -1);
        else begin
          logic [7:0] e;
          e = expMosi.pop_front();
          chk(slvIn == e, monTag, int'(slvIn), int'(e));
        end
        slvBits = 0;
        slvIdx++;
        slvByte = resp(slvIdx);
      end
    end else if (lastSclk) begin
      lastSclk = 1'b0;
      miso = slvByte[3'(7 - slvBits)];
    end else begin
      slvIdx = 0;
      slvBits = 0;
      slvByte = resp(0);
      miso = slvByte[7];
    end
  end

  always @(negedge clk) if (doneEvt) doneCount++;

  task automatic queueTx(input logic [7:0] b);
    while (txLevel == 7'd64) @(negedge clk);
    txPush = 1'b1; txData = b; expMosi.push_back(b);
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic queueZeros(input int n);
    for (int i = 0; i < n; i++) expMosi.push_back(8'h00);
  endtask

  task automatic startBurst(input int len, input int tl, input bit pe, input int dv);
    burstLen = 24'(len); txLen = 24'(tl); pauseEn = pe; clkDiv = 8'(dv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic popCheck(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      while (rxLevel == 0) @(negedge clk);
      chk(rxData == resp(k), req, int'(rxData), int'(resp(k)));
      rxPop = 1'b1;
      @(negedge clk);
      rxPop = 1'b0;
    end
  endtask

  task automatic waitDoneCount(input int target);
    while (doneCount < target) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog actual=%0h expected=%0h", doneCount, 0);
    finish();
  end

  initial begin
    int cnt, rises, d0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1", csN, 1);
    chk(sclk == 1'b0, "R1", sclk, 0);
    chk(busy == 1'b0 && doneEvt == 1'b0, "R1", {busy, doneEvt}, 0);
    chk(txLevel == 0 && rxLevel == 0, "R1", {txLevel, rxLevel}, 0);

    // R2 R3 R8 R9 R12: four FIFO bytes, divider 2
    monTag = "R2";
    queueTx(8'hA5); queueTx(8'h3C); queueTx(8'hF0); queueTx(8'h0F);
    chk(txLevel == 7'd4, "R11", int'(txLevel), 4);
    startBurst(4, 4, 1'b1, 2);
    cnt = 1;
    while (!sclk) begin @(negedge clk); cnt++; end
    chk(cnt >= 3, "R12", cnt, 3);
    cnt = 0;
    while (sclk) begin @(negedge clk); cnt++; end
    chk(cnt == 3, "R9", cnt, 3);
    while (!doneEvt) @(negedge clk);
    chk(csN == 1'b1 && busy == 1'b0, "R8", {csN, busy}, 2);
    @(negedge clk);
    chk(doneEvt == 1'b0, "R8", doneEvt, 0);
    chk(slvIdx == 4, "R8", slvIdx, 4);
    chk(expMosi.size() == 0, "R2", expMosi.size(), 0);
    popCheck(4, "R3");

    // R4 zero fill after the transmit count
    monTag = "R4";
    d0 = doneCount;
    queueTx(8'h81); queueTx(8'h7E); queueZeros(3);
    startBurst(5, 2, 1'b1, 1);
    waitDoneCount(d0 + 1);
    chk(expMosi.size() == 0, "R4", expMosi.size(), 0);
    chk(txLevel == 0, "R4", int'(txLevel), 0);
    popCheck(5, "R3");

    // R5 transmit starvation
    monTag = "R5";
    d0 = doneCount;
    startBurst(3, 3, 1'b1, 0);
    rises = sclkRises;
    repeat (100) @(negedge clk);
    chk(busy && !csN && !sclk, "R5", {busy, csN, sclk}, 4);
    chk(sclkRises == rises, "R5", sclkRises, rises);
    queueTx(8'h11); queueTx(8'h22); queueTx(8'h33);
    waitDoneCount(d0 + 1);
    chk(expMosi.size() == 0, "R5", expMosi.size(), 0);
    popCheck(3, "R5");

    // R10 zero-length start ignored
    startBurst(0, 0, 1'b1, 0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && csN == 1'b1, "R10", {busy, csN}, 1);

    // R6 R10 R11: 100 bytes with pause, host withholds pops
    monTag = "R6";
    d0 = doneCount;
    for (int i = 0; i < 64; i++) queueTx(8'(i * 3 + 1));
    txPush = 1'b1; txData = 8'hEE;
    @(negedge clk);
    txPush = 1'b0;
    chk(txLevel == 7'd64, "R11", int'(txLevel), 64);
    startBurst(100, 100, 1'b1, 0);
    repeat (3) @(negedge clk);
    startBurst(5, 5, 1'b1, 0);
    for (int i = 64; i < 100; i++) queueTx(8'(i * 3 + 1));
    while (rxLevel != 7'd64) @(negedge clk);
    rises = sclkRises;
    repeat (100) @(negedge clk);
    chk(sclkRises == rises && busy, "R6", sclkRises, rises);
    chk(rxLevel == 7'd64, "R6", int'(rxLevel), 64);
    popCheck(100, "R6");
    waitDoneCount(d0 + 1);
    chk(slvIdx == 100, "R10", slvIdx, 100);
    chk(expMosi.size() == 0, "R6", expMosi.size(), 0);

    // R7: no pause, overflow drops late bytes
    monTag = "R7";
    d0 = doneCount;
    queueZeros(70);
    startBurst(70, 0, 1'b0, 0);
    waitDoneCount(d0 + 1);
    chk(slvIdx == 70, "R7", slvIdx, 70);
    chk(rxLevel == 7'd64, "R7", int'(rxLevel), 64);
    popCheck(64, "R7");
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
    @(negedge clk);
    chk(rxLevel == 0, "R11", int'(rxLevel), 0);

    finish();
  end
endmodule